// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers level-sensitive interrupt requests into two CPU interrupt lines. It has two primary groups, A and B, each eight requests wide. It also has one shared eight-bit bank of secondary requests. Every group has a mask register, and a group's pending set is its status ANDed with its mask. The secondary bank is qualified by two independent masks. Each qualified result collapses into a single bit of a primary group: secondary mask 0 feeds group A bit 7, and secondary mask 1 feeds group B bit 3. The raw request wired to each of those two positions is not used.

All request inputs and a small set of busy flags are brought into the clock domain through a chain of synchronising flops. Software reaches the block over a plain 32-bit register port. Reads are combinational and writes take effect on the clock edge. Software clears the masks at start-up, sets mask bits to enable sources, and polls the busy flags in the group A status word until they drop.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While reset is asserted, and immediately after it, all four mask registers read zero and both `irq0_o` and `irq1_o` are low.
- R2: A write to a mask word (word index 1 = group A mask, 3 = group B mask, 5 = secondary mask 0, 6 = secondary mask 1) stores data bits [7:0] on that clock edge. A read of the same index returns them with bits [31:8] zero.
- R3: A change on any request or busy input appears in the status words after exactly two rising clock edges.
- R4: Writes to the status words (indexes 0, 2 and 4) are ignored. No mask and no status value changes.
- R5: `irq0_o` is high exactly when group A status ANDed with group A mask is non-zero. It follows a mask write in the same cycle.
- R6: `irq1_o` is high exactly when group B status ANDed with group B mask is non-zero.
- R7: Group A status bit 7 (index 0) is the OR of the synchronised secondary requests ANDed with secondary mask 0. The raw group A input bit 7 is ignored.
- R8: Group B status bit 3 (index 2) is the OR of the synchronised secondary requests ANDed with secondary mask 1. The raw group B input bit 3 is ignored.
- R9: Index 4 returns the synchronised secondary requests in bits [7:0], unmasked.
- R10: The synchronised busy flags read back in bits [11:8] of index 0. They never affect either interrupt output.
- R11: A read of index 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Word index of the register access |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| grp_a_req_i | input | 8 | Group A request levels |
| grp_b_req_i | input | 8 | Group B request levels |
| sec_req_i | input | 8 | Shared secondary request levels |
| busy_i | input | 4 | Busy flags shown in group A status |
| irq0_o | output | 1 | CPU interrupt from group A |
| irq1_o | output | 1 | CPU interrupt from group B |

## Verification
The properties assume the request inputs behave as levels sampled by the synchroniser. The delay checks only apply once two edges have passed since reset, so no input seen during reset enters the comparison. They also assume the write strobe stays low while reset is held. The stimulus drives every input a fixed time after the rising edge and holds it through the next one. It keeps the write strobe low during reset and changes requests freely, as the synchroniser expects, including in the randomised phase.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int REG_AW = 3;
   localparam int NUM_MASKS = 4;

   typedef enum logic [REG_AW-1:0] {
      RA_A_STAT  = 3'd0,
      RA_A_MASK  = 3'd1,
      RA_B_STAT  = 3'd2,
      RA_B_MASK  = 3'd3,
      RA_S_STAT  = 3'd4,
      RA_S_MASK0 = 3'd5,
      RA_S_MASK1 = 3'd6,
      RA_NONE    = 3'd7
   } reg_addr_e;

   // mask slot order inside the mask bank
   localparam int MS_A  = 0;
   localparam int MS_B  = 1;
   localparam int MS_S0 = 2;
   localparam int MS_S1 = 3;
endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cic_mask_reg.sv
module cic_mask_reg #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [W-1:0] wd_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (we_i) q_o <= wd_i;
   end
endmodule

// File: rtl/cic_group.sv
module cic_group #(
   parameter int W        = 8,
   parameter int CASC_BIT = 7
) (
   input  logic [W-1:0] raw_i,
   input  logic         casc_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] status_o,
   output logic         irq_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == CASC_BIT) begin : g_casc
         assign status_o[b] = casc_i;
      end else begin : g_raw
         assign status_o[b] = raw_i[b];
      end
   end

   assign irq_o = |(status_o & mask_i);

   logic unused_casc_raw;
   assign unused_casc_raw = raw_i[CASC_BIT];
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
   import cic_pkg::*;
#(
   parameter int GRP_W       = 8,
   parameter int DATA_W      = 32,
   parameter int BUSY_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CASC0_BIT   = 7,
   parameter int CASC1_BIT   = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [GRP_W-1:0]  grp_a_req_i,
   input  logic [GRP_W-1:0]  grp_b_req_i,
   input  logic [GRP_W-1:0]  sec_req_i,
   input  logic [BUSY_W-1:0] busy_i,
   output logic              irq0_o,
   output logic              irq1_o
);
   localparam int SYNC_W = 3*GRP_W + BUSY_W;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CASC0_BIT >= GRP_W || CASC1_BIT >= GRP_W) begin : g_bad_casc
      $error("cascade bit positions must lie inside a group");
   end
   if (BUSY_W < 1 || GRP_W + BUSY_W > DATA_W) begin : g_bad_busy
      $error("busy flags must fit in the status word");
   end
   if (GRP_W >= DATA_W) begin : g_bad_grp
      $error("group width must be below the data width");
   end

   // input synchronisation
   logic [SYNC_W-1:0] sync_q;
   logic [GRP_W-1:0]  a_sync, b_sync, sec_sync;
   logic [BUSY_W-1:0] busy_sync;

   cic_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({busy_i, sec_req_i, grp_b_req_i, grp_a_req_i}),
      .q_o   (sync_q)
   );
   assign {busy_sync, sec_sync, b_sync, a_sync} = sync_q;

   // mask bank
   logic [NUM_MASKS-1:0] mask_we;
   logic [GRP_W-1:0]     mask_q [NUM_MASKS];
   logic [GRP_W-1:0]     a_mask, b_mask, s0_mask, s1_mask;

   always_comb begin
      mask_we        = '0;
      mask_we[MS_A]  = wr_en_i && (addr_i == RA_A_MASK);
      mask_we[MS_B]  = wr_en_i && (addr_i == RA_B_MASK);
      mask_we[MS_S0] = wr_en_i && (addr_i == RA_S_MASK0);
      mask_we[MS_S1] = wr_en_i && (addr_i == RA_S_MASK1);
   end

   for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
      cic_mask_reg #(.W(GRP_W)) u_mask (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .we_i  (mask_we[m]),
         .wd_i  (wr_data_i[GRP_W-1:0]),
         .q_o   (mask_q[m])
      );
   end

   assign a_mask  = mask_q[MS_A];
   assign b_mask  = mask_q[MS_B];
   assign s0_mask = mask_q[MS_S0];
   assign s1_mask = mask_q[MS_S1];

   logic unused_wd;
   assign unused_wd = ^wr_data_i[DATA_W-1:GRP_W];

   // secondary bank collapses into one bit of each primary group
   logic sec_hit0, sec_hit1;
   assign sec_hit0 = |(sec_sync & s0_mask);
   assign sec_hit1 = |(sec_sync & s1_mask);

   logic [GRP_W-1:0] a_status, b_status;

   cic_group #(.W(GRP_W), .CASC_BIT(CASC0_BIT)) u_grp_a (
      .raw_i   (a_sync),
      .casc_i  (sec_hit0),
      .mask_i  (a_mask),
      .status_o(a_status),
      .irq_o   (irq0_o)
   );

   cic_group #(.W(GRP_W), .CASC_BIT(CASC1_BIT)) u_grp_b (
      .raw_i   (b_sync),
      .casc_i  (sec_hit1),
      .mask_i  (b_mask),
      .status_o(b_status),
      .irq_o   (irq1_o)
   );

   // read mux
   always_comb begin
      rd_data_o = '0;
      unique case (reg_addr_e'(addr_i))
         RA_A_STAT: begin
            rd_data_o[GRP_W-1:0]       = a_status;
            rd_data_o[GRP_W +: BUSY_W] = busy_sync;
         end
         RA_A_MASK:  rd_data_o[GRP_W-1:0] = a_mask;
         RA_B_STAT:  rd_data_o[GRP_W-1:0] = b_status;
         RA_B_MASK:  rd_data_o[GRP_W-1:0] = b_mask;
         RA_S_STAT:  rd_data_o[GRP_W-1:0] = sec_sync;
         RA_S_MASK0: rd_data_o[GRP_W-1:0] = s0_mask;
         RA_S_MASK1: rd_data_o[GRP_W-1:0] = s1_mask;
         default:    rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
   parameter int GRP_W     = 8,
   parameter int CASC0_BIT = 7,
   parameter int CASC1_BIT = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [2:0]       addr_i,
   input logic             wr_en_i,
   input logic [GRP_W-1:0] wr_low_i,
   input logic [GRP_W-1:0] sec_req_i,
   input logic             irq0_o,
   input logic             irq1_o,
   input logic [GRP_W-1:0] a_mask,
   input logic [GRP_W-1:0] b_mask,
   input logic [GRP_W-1:0] s0_mask,
   input logic [GRP_W-1:0] s1_mask,
   input logic [GRP_W-1:0] sec_sync
);
   // edges seen since reset release, saturating
   logic [1:0] since_rst;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 since_rst <= '0;
      else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
   end

   always @(negedge clk_i) begin
      if (!rst_ni) begin
         assert_reset_quiet_R1: assert (!irq0_o && !irq1_o)
            else $error("irq output high during reset");
      end
   end

   assert_mask_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 3'd1) |=> (a_mask == $past(wr_low_i)));

   assert_status_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (addr_i == 3'd0 || addr_i == 3'd2 || addr_i == 3'd4))
      |=> ($stable(a_mask) && $stable(b_mask) && $stable(s0_mask) && $stable(s1_mask)));

   assert_sync_delay_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2'd2) |-> (sec_sync == $past(sec_req_i, 2)));

   assert_irq0_needs_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_mask == '0) |-> !irq0_o);

   assert_irq1_needs_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_mask == '0) |-> !irq1_o);

   assert_cascade0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2'd2 && (($past(sec_req_i, 2) & s0_mask) != '0) && a_mask[CASC0_BIT])
      |-> irq0_o);

   assert_cascade1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2'd2 && (($past(sec_req_i, 2) & s1_mask) != '0) && b_mask[CASC1_BIT])
      |-> irq1_o);
endmodule

bind cascade_irq_ctrl cic_checker #(
   .GRP_W    (GRP_W),
   .CASC0_BIT(CASC0_BIT),
   .CASC1_BIT(CASC1_BIT)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .addr_i   (addr_i),
   .wr_en_i  (wr_en_i),
   .wr_low_i (wr_data_i[GRP_W-1:0]),
   .sec_req_i(sec_req_i),
   .irq0_o   (irq0_o),
   .irq1_o   (irq1_o),
   .a_mask   (a_mask),
   .b_mask   (b_mask),
   .s0_mask  (s0_mask),
   .s1_mask  (s1_mask),
   .sec_sync (sec_sync)
);

// File: tb/tb_cascade_irq_ctrl.sv
module tb_cascade_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  addr;
   logic        we;
   logic [31:0] wd;
   logic [31:0] rd;
   logic [7:0]  ra, rb, rs;
   logic [3:0]  busy;
   logic        irq0, irq1;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cascade_irq_ctrl dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .addr_i     (addr),
      .wr_en_i    (we),
      .wr_data_i  (wd),
      .rd_data_o  (rd),
      .grp_a_req_i(ra),
      .grp_b_req_i(rb),
      .sec_req_i  (rs),
      .busy_i     (busy),
      .irq0_o     (irq0),
      .irq1_o     (irq1)
   );

   // ---------------- behavioural reference ----------------
   logic [27:0] hist [$];
   logic [7:0]  m_a, m_b, m_s0, m_s1;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         m_a = 0; m_b = 0; m_s0 = 0; m_s1 = 0;
      end else begin
         if (we) begin
            case (addr)
               3'd1: m_a  = wd[7:0];
               3'd3: m_b  = wd[7:0];
               3'd5: m_s0 = wd[7:0];
               3'd6: m_s1 = wd[7:0];
               default: ;
            endcase
         end
         hist.push_front({busy, rs, rb, ra});
         if (hist.size() > 2) void'(hist.pop_back());
      end
   end

   function automatic logic [27:0] seen();
      return (hist.size() >= 2) ? hist[1] : 28'd0;
   endfunction

   function automatic logic [7:0] exp_a();
      logic [27:0] s = seen();
      logic [7:0]  v = s[7:0];
      v[7] = |(s[23:16] & m_s0);
      return v;
   endfunction

   function automatic logic [7:0] exp_b();
      logic [27:0] s = seen();
      logic [7:0]  v = s[15:8];
      v[3] = |(s[23:16] & m_s1);
      return v;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [2:0] a);
      logic [27:0] s = seen();
      case (a)
         3'd0: return {20'd0, s[27:24], exp_a()};
         3'd1: return {24'd0, m_a};
         3'd2: return {24'd0, exp_b()};
         3'd3: return {24'd0, m_b};
         3'd4: return {24'd0, s[23:16]};
         3'd5: return {24'd0, m_s0};
         3'd6: return {24'd0, m_s1};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [2:0] a);
      case (a)
         3'd0: return "R7";
         3'd2: return "R8";
         3'd4: return "R9";
         3'd7: return "R11";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk(!irq0 && !irq1, "R1", {30'd0, irq1, irq0}, 32'd0);
         end else begin
            chk(irq0 == |(exp_a() & m_a), "R5", {31'd0, irq0}, {31'd0, |(exp_a() & m_a)});
            chk(irq1 == |(exp_b() & m_b), "R6", {31'd0, irq1}, {31'd0, |(exp_b() & m_b)});
            chk(rd == exp_rd(addr), rd_tag(addr), rd, exp_rd(addr));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      addr = a; wd = d; we = 1'b1;
      cyc(1);
      we = 1'b0;
   endtask

   task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      addr = a;
      @(negedge clk);
      chk(rd == e, tag, rd, e);
      cyc(1);
   endtask

   task automatic expect_irq(input logic e0, input logic e1, input string tag);
      @(negedge clk);
      chk(irq0 == e0 && irq1 == e1, tag, {30'd0, irq1, irq0}, {30'd0, e1, e0});
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      rst_n = 1'b0; addr = 3'd0; we = 1'b0; wd = 32'd0;
      ra = 8'd0; rb = 8'd0; rs = 8'd0; busy = 4'd0;
      cyc(5);
      rst_n = 1'b1;

      // R1: masks clear and outputs quiet after reset
      expect_rd(3'd1, 32'd0, "R1");
      expect_rd(3'd3, 32'd0, "R1");
      expect_rd(3'd5, 32'd0, "R1");
      expect_rd(3'd6, 32'd0, "R1");
      expect_irq(1'b0, 1'b0, "R1");
      cyc(1);

      // R2: store low byte, upper bits read zero
      wr(3'd1, 32'hFFFF_FF81);
      expect_rd(3'd1, 32'h0000_0081, "R2");
      wr(3'd3, 32'h0000_000F);
      expect_rd(3'd3, 32'h0000_000F, "R2");

      // R3: two-edge synchroniser latency seen at irq0
      ra = 8'h01;
      cyc(1);
      expect_irq(1'b0, 1'b0, "R3");
      cyc(1);
      expect_irq(1'b1, 1'b0, "R3");
      cyc(1);

      // R4: status writes ignored
      wr(3'd0, 32'h0000_00FF);
      wr(3'd2, 32'h0000_00FF);
      wr(3'd4, 32'h0000_00FF);
      expect_rd(3'd1, 32'h0000_0081, "R4");
      expect_rd(3'd0, 32'h0000_0001, "R4");
      expect_rd(3'd3, 32'h0000_000F, "R4");

      // R7: raw bit 7 of group A ignored, cascade drives it
      ra = 8'h80;
      cyc(3);
      expect_rd(3'd0, 32'h0000_0000, "R7");
      expect_irq(1'b0, 1'b0, "R7");
      cyc(1);
      rs = 8'h10;
      wr(3'd5, 32'h0000_0010);
      cyc(3);
      expect_rd(3'd0, 32'h0000_0080, "R7");
      expect_irq(1'b1, 1'b0, "R7");
      cyc(1);
      wr(3'd5, 32'h0000_0001);
      expect_irq(1'b0, 1'b0, "R5");
      cyc(1);

      // R8 / R9: second cascade into group B bit 3
      wr(3'd6, 32'h0000_0010);
      expect_irq(1'b0, 1'b1, "R8");
      cyc(1);
      expect_rd(3'd2, 32'h0000_0008, "R8");
      expect_rd(3'd4, 32'h0000_0010, "R9");
      rb = 8'h08;
      wr(3'd6, 32'h0000_0000);
      cyc(3);
      expect_rd(3'd2, 32'h0000_0000, "R8");
      expect_irq(1'b0, 1'b0, "R6");
      cyc(1);

      // R10: busy flags visible, no interrupt effect
      wr(3'd1, 32'h0000_00FF);
      busy = 4'hA;
      cyc(3);
      expect_rd(3'd0, 32'h0000_0A00, "R10");
      expect_irq(1'b0, 1'b0, "R10");
      cyc(1);

      // R11: unused index
      expect_rd(3'd7, 32'h0000_0000, "R11");

      // randomised phase, compared every clock
      for (int i = 0; i < 400; i++) begin
         ra   = 8'($urandom);
         rb   = 8'($urandom);
         rs   = 8'($urandom);
         busy = 4'($urandom);
         addr = 3'($urandom);
         wd   = $urandom;
         we   = ($urandom_range(0, 3) == 0);
         cyc(1);
      end
      we = 1'b0;
      cyc(3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule